// File: doc/BRIEF.md
# Paged Transfer Buffer Address Walker

This block produces the physical byte address of each data beat for a transfer. The transfer's buffer is contiguous in virtual space but lies on a list of 4 KB physical pages. Software loads three things in one cycle: a short list of page pointers, a starting byte offset inside the first page, and a total byte count. The walker then gives the current physical address, the index of the page pointer in use and the bytes still to move. Each accepted data beat advances the walker by the number of bytes that beat carries.

A beat never straddles a page. The walker tells the bus side how many bytes the offered beat may carry (`beat_take`), and that number is limited by the requested beat size, the bytes left and the room left in the current page. When the in-page offset reaches the end of a page, the walker switches to the next list entry. This happens even when the next physical page sits directly after the current one. A load that would need more pages than the list holds is rejected with an error flag, and no addresses are produced for it.

Top module: `buf_addr_walker`

## Requirements
- R1: One cycle after a load, `addr_out` holds the upper bits of pointer 0 joined with `load_offset`, `page_idx` is 0 and `bytes_left` equals `load_count`.
- R2: Bits 11 to 0 of every loaded page pointer are ignored, and `addr_out[31:12]` always comes from the selected pointer's bits 31 to 12.
- R3: A load with `load_offset + load_count > 20480` sets `load_err`, holds `beat_ready` and `done` low and accepts no beats. The next load that fits clears `load_err`, and `load_offset + load_count == 20480` is accepted.
- R4: `beat_ready` is high exactly when a load without error is in force and `bytes_left` is non-zero. A `beat_valid` while `beat_ready` is low changes nothing.
- R5: `beat_take` is the smallest of `beat_size`, `bytes_left` and 4096 minus the current in-page offset. It is 0 when `beat_size` is 0 or above 4, or when `beat_ready` is low.
- R6: A beat with `beat_valid`, `beat_ready` and a non-zero `beat_take` does two things in the next cycle: the in-page offset rises by `beat_take` and `bytes_left` falls by `beat_take`.
- R7: When an accepted beat brings the offset to 4096, the offset restarts at 0 and `page_idx` increments, unless that beat ends the transfer. In that case `page_idx` stays put. `page_idx` never reaches 5.
- R8: `done` is high when a load without error is in force and `bytes_left` is 0. A load with a count of 0 raises `done` at once.
- R9: After reset, `beat_ready`, `done` and `load_err` are low, and `page_idx` and `bytes_left` are 0.
- R10: A load in the same cycle as an accepted beat wins. The state afterwards reflects only the new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_valid | input | 1 | Load the pointer list, offset and count this cycle |
| load_ptrs | input | 160 | Five 32-bit page pointers; entry i at bits [32*i+31:32*i] |
| load_offset | input | 12 | Starting byte offset inside the first page |
| load_count | input | 15 | Total transfer length in bytes |
| beat_valid | input | 1 | Bus side offers a data beat |
| beat_size | input | 3 | Requested beat size in bytes (1 to 4 valid) |
| beat_ready | output | 1 | Walker can accept a beat |
| beat_take | output | 3 | Bytes the offered beat may carry |
| addr_out | output | 32 | Physical byte address of the current beat |
| page_idx | output | 3 | Index of the page pointer in use |
| bytes_left | output | 15 | Bytes still to transfer |
| done | output | 1 | Transfer complete |
| load_err | output | 1 | Last load needed more pages than the list holds |

## Verification
`beat_take` and `beat_ready` are combinational from the walker state and the offered beat size. The bench therefore samples them one time unit after driving the beat, before the clock edge that accepts it. Every registered result (`addr_out`, `page_idx`, `bytes_left`, `done`, `load_err`) is due one cycle after the edge that took the load or beat. The bench reads those one time unit after that same edge, so each expected value is compared in the cycle the single register stage makes it visible. In the long transfer, a bench-side model of offset and page index is stepped once per accepted beat and compared with `addr_out` before every beat.

// File: rtl/bw_pkg.sv
package bw_pkg;

   // smallest of three unsigned values, all passed at a common width
   function automatic logic [31:0] min3(input logic [31:0] a,
                                        input logic [31:0] b,
                                        input logic [31:0] c);
      logic [31:0] m;
      m = a;
      if (b < m) m = b;
      if (c < m) m = c;
      return m;
   endfunction

   // width of an index able to address n entries (at least one bit)
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/bw_load_check.sv
module bw_load_check #(
   parameter int PAGE_W    = 12,
   parameter int NUM_PAGES = 5,
   parameter int CNT_W     = 15
) (
   input  logic [PAGE_W-1:0] start_off,
   input  logic [CNT_W-1:0]  count,
   output logic              too_big
);
   localparam int SUM_W = CNT_W + 1;
   localparam logic [SUM_W-1:0] CAPACITY = SUM_W'(NUM_PAGES * (1 << PAGE_W));

   logic [SUM_W-1:0] span;

   always_comb begin
      span    = SUM_W'(start_off) + SUM_W'(count);
      too_big = (span > CAPACITY);
   end
endmodule

// File: rtl/bw_page_table.sv
module bw_page_table #(
   parameter int ADDR_W    = 32,
   parameter int PAGE_W    = 12,
   parameter int NUM_PAGES = 5,
   parameter int IDX_W     = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [NUM_PAGES*ADDR_W-1:0] wr_ptrs,
   input  logic [IDX_W-1:0]            sel,
   output logic [ADDR_W-PAGE_W-1:0]    frame
);
   localparam int FRAME_W = ADDR_W - PAGE_W;

   logic [FRAME_W-1:0] frames [NUM_PAGES];

   // only the page-frame bits of each pointer are kept
   for (genvar g = 0; g < NUM_PAGES; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            frames[g] <= '0;
         else if (wr_en)
            frames[g] <= wr_ptrs[g*ADDR_W + PAGE_W +: FRAME_W];
      end
   end

   if (NUM_PAGES == 1) begin : g_single
      assign frame = frames[0];
      logic unused_sel;
      assign unused_sel = ^sel;
   end else begin : g_mux
      always_comb begin
         frame = '0;
         for (int i = 0; i < NUM_PAGES; i++)
            if (sel == IDX_W'(i)) frame = frames[i];
      end
   end
endmodule

// File: rtl/bw_cursor.sv
module bw_cursor #(
   parameter int PAGE_W    = 12,
   parameter int NUM_PAGES = 5,
   parameter int CNT_W     = 15,
   parameter int IDX_W     = 3,
   parameter int BS_W      = 3,
   parameter int MAX_BEAT  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              load_bad,
   input  logic [PAGE_W-1:0] load_off,
   input  logic [CNT_W-1:0]  load_cnt,
   input  logic              beat_valid,
   input  logic [BS_W-1:0]   beat_size,
   output logic              ready,
   output logic              fin,
   output logic              err,
   output logic [BS_W-1:0]   take,
   output logic [PAGE_W-1:0] off,
   output logic [IDX_W-1:0]  idx,
   output logic [CNT_W-1:0]  left
);
   import bw_pkg::*;

   localparam int PAGE_BYTES = 1 << PAGE_W;
   localparam int OFF_SUM_W  = PAGE_W + 1;

   logic                 loaded;
   logic [31:0]          room;
   logic [31:0]          t_raw;
   logic                 size_ok;
   logic                 fire;
   logic [OFF_SUM_W-1:0] off_sum;
   logic                 ends_xfer;

   assign ready = loaded && !err && (left != '0);
   assign fin   = loaded && !err && (left == '0);

   always_comb begin
      room    = 32'(PAGE_BYTES) - 32'(off);
      size_ok = (beat_size != '0) && (32'(beat_size) <= 32'(MAX_BEAT));
      t_raw   = min3(32'(beat_size), 32'(left), room);
      take    = (ready && size_ok) ? BS_W'(t_raw) : '0;
      fire    = beat_valid && (take != '0);
      off_sum = OFF_SUM_W'(off) + OFF_SUM_W'(take);
      ends_xfer = (left == CNT_W'(take));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loaded <= 1'b0;
         err    <= 1'b0;
         off    <= '0;
         idx    <= '0;
         left   <= '0;
      end else if (load) begin
         loaded <= 1'b1;
         err    <= load_bad;
         off    <= load_off;
         idx    <= '0;
         left   <= load_bad ? '0 : load_cnt;
      end else if (fire) begin
         left <= left - CNT_W'(take);
         if (off_sum[PAGE_W]) begin
            off <= '0;
            if (!ends_xfer) idx <= idx + 1'b1;
         end else begin
            off <= off_sum[PAGE_W-1:0];
         end
      end
   end

   // R5: a beat never carries more than is left
   p_take_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      CNT_W'(take) <= left);

   // R7: the pointer index stays inside the list
   p_idx_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      32'(idx) < 32'(NUM_PAGES));

   // R6: an accepted beat reduces the remaining count by what it carried
   p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !load) |=> (left == $past(left) - CNT_W'($past(take))));

   // R7: reaching the page end moves to the next pointer at offset zero
   p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !load && off_sum[PAGE_W] && !ends_xfer)
      |=> (off == '0 && idx == $past(idx) + 1'b1));

   // R3: a rejected load never offers a beat
   p_err_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !ready);
endmodule

// File: rtl/buf_addr_walker.sv
module buf_addr_walker #(
   parameter int ADDR_W    = 32,
   parameter int PAGE_W    = 12,
   parameter int NUM_PAGES = 5,
   parameter int MAX_BEAT  = 4,
   parameter int CNT_W     = $clog2(NUM_PAGES * (1 << PAGE_W) + 1),
   parameter int IDX_W     = bw_pkg::idx_width(NUM_PAGES),
   parameter int BS_W      = $clog2(MAX_BEAT + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load_valid,
   input  logic [NUM_PAGES*ADDR_W-1:0] load_ptrs,
   input  logic [PAGE_W-1:0]           load_offset,
   input  logic [CNT_W-1:0]            load_count,
   input  logic                        beat_valid,
   input  logic [BS_W-1:0]             beat_size,
   output logic                        beat_ready,
   output logic [BS_W-1:0]             beat_take,
   output logic [ADDR_W-1:0]           addr_out,
   output logic [IDX_W-1:0]            page_idx,
   output logic [CNT_W-1:0]            bytes_left,
   output logic                        done,
   output logic                        load_err
);
   if (PAGE_W < 1 || ADDR_W <= PAGE_W) begin : g_bad_widths
      $error("buf_addr_walker: ADDR_W must exceed PAGE_W >= 1");
   end
   if (NUM_PAGES < 1) begin : g_bad_pages
      $error("buf_addr_walker: NUM_PAGES must be at least 1");
   end
   if (MAX_BEAT < 1 || MAX_BEAT > (1 << PAGE_W)) begin : g_bad_beat
      $error("buf_addr_walker: MAX_BEAT out of range");
   end

   logic                     too_big;
   logic [ADDR_W-PAGE_W-1:0] frame;
   logic [PAGE_W-1:0]        off;

   bw_load_check #(
      .PAGE_W(PAGE_W), .NUM_PAGES(NUM_PAGES), .CNT_W(CNT_W)
   ) u_check (
      .start_off(load_offset),
      .count    (load_count),
      .too_big  (too_big)
   );

   bw_page_table #(
      .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W)
   ) u_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (load_valid),
      .wr_ptrs(load_ptrs),
      .sel    (page_idx),
      .frame  (frame)
   );

   bw_cursor #(
      .PAGE_W(PAGE_W), .NUM_PAGES(NUM_PAGES), .CNT_W(CNT_W),
      .IDX_W(IDX_W), .BS_W(BS_W), .MAX_BEAT(MAX_BEAT)
   ) u_cursor (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_valid),
      .load_bad  (too_big),
      .load_off  (load_offset),
      .load_cnt  (load_count),
      .beat_valid(beat_valid),
      .beat_size (beat_size),
      .ready     (beat_ready),
      .fin       (done),
      .err       (load_err),
      .take      (beat_take),
      .off       (off),
      .idx       (page_idx),
      .left      (bytes_left)
   );

   assign addr_out = {frame, off};

   // R8: a finished transfer offers no beat
   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!beat_ready && bytes_left == '0));

   // R4: a beat offered while not ready leaves the address untouched
   p_no_ready_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!beat_ready && !load_valid) |=> $stable(addr_out));
endmodule

// File: tb/buf_addr_walker_test.sv
module buf_addr_walker_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         load_valid = 1'b0;
   logic [159:0] load_ptrs = '0;
   logic [11:0]  load_offset = '0;
   logic [14:0]  load_count = '0;
   logic         beat_valid = 1'b0;
   logic [2:0]   beat_size = '0;
   logic         beat_ready;
   logic [2:0]   beat_take;
   logic [31:0]  addr_out;
   logic [2:0]   page_idx;
   logic [14:0]  bytes_left;
   logic         done;
   logic         load_err;

   int total = 0;
   int bad = 0;
   logic [31:0] ptr [5];

   always #2 clk = ~clk;

   buf_addr_walker uut (
      .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_ptrs(load_ptrs),
      .load_offset(load_offset), .load_count(load_count), .beat_valid(beat_valid),
      .beat_size(beat_size), .beat_ready(beat_ready), .beat_take(beat_take),
      .addr_out(addr_out), .page_idx(page_idx), .bytes_left(bytes_left),
      .done(done), .load_err(load_err)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] page_addr(input int i, input int o);
      return {ptr[i][31:12], 12'(o)};
   endfunction

   // all timing: inputs change 1 unit after a rising edge, outputs read there too
   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic do_load(input int o, input int n);
      load_valid  = 1'b1;
      load_offset = 12'(o);
      load_count  = 15'(n);
      tick();
      load_valid  = 1'b0;
   endtask

   task automatic do_beat(input int sz);
      beat_valid = 1'b1;
      beat_size  = 3'(sz);
      tick();
      beat_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk(!beat_ready, "R9 ready", beat_ready, 0);
      chk(!done && !load_err, "R9 done/err", {done, load_err}, 0);
      chk(page_idx == 0 && bytes_left == 0, "R9 idx/left", bytes_left, 0);
   endtask

   task automatic t_last_byte_start();
      do_load(4095, 2);
      chk(addr_out == page_addr(0, 4095), "R1 R2 start addr", addr_out, page_addr(0, 4095));
      chk(bytes_left == 2 && page_idx == 0, "R1 left", bytes_left, 2);
      beat_size = 3'd4;
      #1;
      chk(beat_take == 1, "R5 page-limited take", beat_take, 1);
      do_beat(4);
      chk(addr_out == page_addr(1, 0) && page_idx == 1, "R7 cross to page 1", addr_out, page_addr(1, 0));
      chk(bytes_left == 1, "R6 left after beat", bytes_left, 1);
      do_beat(4);
      chk(done && !beat_ready && bytes_left == 0, "R8 done after 2 bytes", {done, beat_ready}, 2'b10);
   endtask

   task automatic t_full();
      int o = 0;
      int p = 0;
      int mism = 0;
      int idx_mism = 0;
      do_load(0, 20480);
      for (int b = 0; b < 5120; b++) begin
         if (addr_out !== page_addr(p, o)) mism++;
         if (page_idx !== 3'(p)) idx_mism++;
         do_beat(4);
         o += 4;
         if (o == 4096 && b != 5119) begin
            o = 0;
            p++;
         end
      end
      chk(mism == 0, "R6 address stream", mism, 0);
      chk(idx_mism == 0, "R7 page index stream", idx_mism, 0);
      chk(page_idx == 4 && addr_out[11:0] == 0, "R7 last page stays", page_idx, 4);
      chk(done && bytes_left == 0, "R8 full transfer done", done, 1);
   endtask

   task automatic t_overflow();
      logic [31:0] a0;
      do_load(100, 20480);
      chk(load_err && !beat_ready && !done, "R3 overflow flagged", {load_err, beat_ready, done}, 3'b100);
      a0 = addr_out;
      do_beat(4);
      chk(addr_out == a0 && bytes_left == 0, "R3 no beat on error", addr_out, a0);
      do_load(4095, 16385);
      chk(!load_err && beat_ready && bytes_left == 16385, "R3 exact fit accepted", load_err, 0);
   endtask

   task automatic t_sizes();
      do_load(10, 3);
      beat_size = 3'd0;
      #1;
      chk(beat_take == 0, "R5 size 0 take", beat_take, 0);
      do_beat(0);
      chk(bytes_left == 3, "R5 size 0 ignored", bytes_left, 3);
      do_beat(5);
      chk(bytes_left == 3 && addr_out == page_addr(0, 10), "R5 size 5 ignored", bytes_left, 3);
      beat_size = 3'd4;
      #1;
      chk(beat_take == 3, "R5 tail take", beat_take, 3);
      do_beat(4);
      chk(done && addr_out == page_addr(0, 13), "R6 tail advance", addr_out, page_addr(0, 13));
      do_beat(2);
      chk(bytes_left == 0 && addr_out == page_addr(0, 13), "R4 beat after done ignored", addr_out, page_addr(0, 13));
   endtask

   task automatic t_zero();
      do_load(0, 0);
      chk(done && !beat_ready, "R8 zero count done", done, 1);
   endtask

   task automatic t_priority();
      do_load(0, 100);
      load_valid  = 1'b1;
      load_offset = 12'd8;
      load_count  = 15'd50;
      beat_valid  = 1'b1;
      beat_size   = 3'd4;
      tick();
      load_valid = 1'b0;
      beat_valid = 1'b0;
      chk(bytes_left == 50 && addr_out == page_addr(0, 8), "R10 load beats beat", bytes_left, 50);
   endtask

   initial begin
      for (int i = 0; i < 5; i++) begin
         ptr[i] = 32'h1000_0000 + 32'(i) * 32'h0030_5000 + 32'(i) * 32'h0000_0ABC + 32'h0000_0F01;
         load_ptrs[i*32 +: 32] = ptr[i];
      end
      #1;
      t_reset();
      #10;
      rst_n = 1'b1;
      tick();
      t_reset();
      t_last_byte_start();
      t_full();
      t_overflow();
      t_sizes();
      t_zero();
      t_priority();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule